// File: doc/BRIEF.md
# Shared-Bus Arbitration State Machine

This block holds the local view of bus ownership for a master that shares one external bus with other devices. It watches the grant input and the core's request, and it decides each bus clock whether the local master owns the bus. If it owns the bus, it also decides whether the master is driving the bus or only holding the grant with the pads three-stated. If it does not own the bus, another device is master. It drives a bus-driven flag, a bus-request line for an external arbiter and a set of pad output enables. All outputs are registered.

A mode input selects the wiring. In two-wire mode one other device shares the bus, and only the grant and bus-driven lines are used, so the request output stays low. In three-wire mode the request output goes to an external arbiter that serves several devices. A synchronous reset or a watchdog reset forces the block to its reset state from any state. When both resets are negated, the level of the grant input decides the next state directly.

Top module: `bus_arb_fsm`

## Requirements
- R1: Whenever `rst` or `wdog_rst` is high at a rising clock edge, `drive_busy`, `req_out` and every bit of `pad_oe` are low after that edge, whatever the state.
- R2: At the first edge with both resets low, the block moves from reset to the granted-idle state if `grant_in` is high, or to the foreign-master state if `grant_in` is low.
- R3: In the granted-idle state with `cpu_req` low, `drive_busy` and `pad_oe` stay low.
- R4: In the granted-idle state, an edge that sees `cpu_req` and `grant_in` both high moves the block to the driving state, so `drive_busy` is high and every `pad_oe` bit is high after that edge.
- R5: In the driving state, an edge that sees `xfer_last` high and `grant_in` low releases the bus. `drive_busy` and `pad_oe` go low and the block enters the foreign-master state.
- R6: In the driving state, an edge that sees `xfer_last` high with `grant_in` high keeps driving if `cpu_req` is high, and returns to the granted-idle state if `cpu_req` is low.
- R7: In the driving state with `xfer_last` low, the block keeps driving even when `grant_in` is low.
- R8: From the foreign-master state, an edge that sees `grant_in` high moves to the granted-idle state. With `cpu_req` held high, driving begins one edge later.
- R9: `req_out` is registered. After an edge it equals `three_wire & cpu_req`, sampled at that edge, provided no reset is active and the new state is not the driving state; otherwise it is low. With `three_wire` low it is always low.
- R10: In the granted-idle state, an edge that sees `grant_in` low moves to the foreign-master state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| wdog_rst | input | 1 | Synchronous active-high watchdog reset |
| three_wire | input | 1 | 1: three-wire mode with request output; 0: two-wire mode |
| grant_in | input | 1 | Bus grant, active high |
| cpu_req | input | 1 | Internal bus request from the core, active high |
| xfer_last | input | 1 | High while the current transfer completes |
| drive_busy | output | 1 | Bus-driven flag, high while this master drives the bus |
| req_out | output | 1 | Bus request to an external arbiter, active high |
| pad_oe | output | OE_LANES | Output enables for the bus pads, all equal |

## Verification
The granted-idle state shows nothing at the ports, because every output is low there and also in the foreign-master state. The stimulus tells the two apart by what happens after a request is raised. From granted-idle, driving starts after one edge. From foreign-master with the grant held low, the bench sees the request line and no driving. The bench uses this probe after leaving reset, after a completed transfer that still had the grant, and after the grant is withdrawn during idle.

// File: rtl/bus_arb_pkg.sv
package bus_arb_pkg;
  typedef enum logic [1:0] {
    ARB_RESET   = 2'd0,
    ARB_IDLE    = 2'd1,
    ARB_DRIVE   = 2'd2,
    ARB_FOREIGN = 2'd3
  } arb_state_t;
endpackage

// File: rtl/bus_arb_next.sv
module bus_arb_next
  import bus_arb_pkg::*;
(
  input  arb_state_t cur,
  input  logic       any_rst,
  input  logic       grant,
  input  logic       req,
  input  logic       last,
  output arb_state_t nxt
);
  always_comb begin
    nxt = cur;
    if (any_rst) begin
      nxt = ARB_RESET;
    end else begin
      unique case (cur)
        ARB_RESET:   nxt = grant ? ARB_IDLE : ARB_FOREIGN;
        ARB_IDLE: begin
          if (!grant)   nxt = ARB_FOREIGN;
          else if (req) nxt = ARB_DRIVE;
        end
        ARB_DRIVE: begin
          if (last) begin
            if (!grant)    nxt = ARB_FOREIGN;
            else if (!req) nxt = ARB_IDLE;
          end
        end
        ARB_FOREIGN: if (grant) nxt = ARB_IDLE;
        default:     nxt = ARB_RESET;
      endcase
    end
  end
endmodule

// File: rtl/bus_arb_outreg.sv
module bus_arb_outreg
  import bus_arb_pkg::*;
#(
  parameter int OE_LANES = 4
) (
  input  logic                clk,
  input  logic                any_rst,
  input  logic                three_wire,
  input  logic                req,
  input  arb_state_t          nxt,
  output logic                drive_q,
  output logic                req_q,
  output logic [OE_LANES-1:0] oe_q
);
  logic drive_d;
  assign drive_d = (nxt == ARB_DRIVE);

  always_ff @(posedge clk) begin
    if (any_rst) begin
      drive_q <= 1'b0;
      req_q   <= 1'b0;
    end else begin
      drive_q <= drive_d;
      req_q   <= three_wire & req & ~drive_d;
    end
  end

  for (genvar g = 0; g < OE_LANES; g++) begin : g_oe
    always_ff @(posedge clk) begin
      if (any_rst) oe_q[g] <= 1'b0;
      else         oe_q[g] <= drive_d;
    end
  end
endmodule

// File: rtl/bus_arb_fsm.sv
module bus_arb_fsm
  import bus_arb_pkg::*;
#(
  parameter int OE_LANES = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wdog_rst,
  input  logic                three_wire,
  input  logic                grant_in,
  input  logic                cpu_req,
  input  logic                xfer_last,
  output logic                drive_busy,
  output logic                req_out,
  output logic [OE_LANES-1:0] pad_oe
);
  arb_state_t state_q, state_d;
  logic       any_rst;

  assign any_rst = rst | wdog_rst;

  bus_arb_next u_next (
    .cur     (state_q),
    .any_rst (any_rst),
    .grant   (grant_in),
    .req     (cpu_req),
    .last    (xfer_last),
    .nxt     (state_d)
  );

  always_ff @(posedge clk) begin
    if (any_rst) state_q <= ARB_RESET;
    else         state_q <= state_d;
  end

  bus_arb_outreg #(.OE_LANES(OE_LANES)) u_out (
    .clk        (clk),
    .any_rst    (any_rst),
    .three_wire (three_wire),
    .req        (cpu_req),
    .nxt        (state_d),
    .drive_q    (drive_busy),
    .req_q      (req_out),
    .oe_q       (pad_oe)
  );
endmodule

// File: rtl/bus_arb_fsm_chk.sv
module bus_arb_fsm_chk #(
  parameter int OE_LANES = 4
) (
  input logic                clk,
  input logic                rst,
  input logic                wdog_rst,
  input logic                three_wire,
  input logic                grant_in,
  input logic                cpu_req,
  input logic                xfer_last,
  input logic                drive_busy,
  input logic                req_out,
  input logic [OE_LANES-1:0] pad_oe
);
  // R1
  wdog_clears_chk: assert property (@(posedge clk) disable iff (rst)
    wdog_rst |=> (!drive_busy && !req_out && pad_oe == '0));
  // R9
  two_wire_no_req_chk: assert property (@(posedge clk) disable iff (rst)
    !three_wire |=> !req_out);
  // R4
  drive_needs_grant_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(drive_busy) |-> $past(grant_in && cpu_req));
  // R5
  release_needs_end_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(drive_busy) |-> $past(xfer_last || rst || wdog_rst));
  // R9
  req_drive_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(req_out && drive_busy));
  // R4
  oe_follows_drive_chk: assert property (@(posedge clk) disable iff (rst)
    pad_oe == {OE_LANES{drive_busy}});
endmodule

bind bus_arb_fsm bus_arb_fsm_chk #(.OE_LANES(OE_LANES)) u_chk (.*);

// File: tb/bus_arb_fsm_test.sv
module bus_arb_fsm_test;
  localparam int LANES = 4;
  logic clk = 1'b0;
  logic rst = 1'b1, wdog_rst = 1'b0, three_wire = 1'b1;
  logic grant_in = 1'b0, cpu_req = 1'b0, xfer_last = 1'b0;
  logic drive_busy, req_out;
  logic [LANES-1:0] pad_oe;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  bus_arb_fsm #(.OE_LANES(LANES)) uut (.*);

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic chk(string tag, logic bd, logic br);
    logic [LANES-1:0] oe_exp;
    oe_exp = {LANES{bd}};
    checks++;
    if (drive_busy !== bd || req_out !== br || pad_oe !== oe_exp) begin
      fails++;
      $display("FAIL %s: bd/br/oe got %b/%b/%b expected %b/%b/%b",
               tag, drive_busy, req_out, pad_oe, bd, br, oe_exp);
    end
  endtask

  task automatic t_reset();
    rst = 1; three_wire = 1; grant_in = 0; cpu_req = 1; step();
    chk("R1 reset", 0, 0);
    rst = 0;
  endtask

  task automatic t_idle_then_drive();
    rst = 1; grant_in = 1; cpu_req = 0; step();
    rst = 0; step();
    chk("R2 reset to idle", 0, 0);
    step();
    chk("R3 idle quiet", 0, 0);
    cpu_req = 1; step();
    chk("R4 drive", 1, 0);
  endtask

  task automatic t_hold_release();
    grant_in = 0; xfer_last = 0; step();
    chk("R7 hold without grant", 1, 0);
    xfer_last = 1; step();
    chk("R5 release", 0, 1);
    xfer_last = 0; step();
    chk("R9 request while foreign", 0, 1);
    grant_in = 1; step();
    chk("R8 foreign to idle", 0, 1);
    step();
    chk("R8 idle to drive", 1, 0);
  endtask

  task automatic t_end_with_grant();
    xfer_last = 1; cpu_req = 1; step();
    chk("R6 keep driving", 1, 0);
    cpu_req = 0; step();
    chk("R6 back to idle", 0, 0);
    xfer_last = 0; cpu_req = 1; step();
    chk("R6 idle probe", 1, 0);
  endtask

  task automatic t_wdog();
    wdog_rst = 1; step();
    chk("R1 watchdog", 0, 0);
    wdog_rst = 0; grant_in = 0; cpu_req = 0; step();
    cpu_req = 1; step();
    chk("R2 reset to foreign", 0, 1);
  endtask

  task automatic t_grant_drop();
    rst = 1; grant_in = 1; cpu_req = 0; step();
    rst = 0; step();
    grant_in = 0; step();
    chk("R10 idle quiet", 0, 0);
    cpu_req = 1; step();
    chk("R10 idle to foreign", 0, 1);
  endtask

  task automatic t_two_wire();
    rst = 1; three_wire = 0; grant_in = 0; cpu_req = 1; step();
    rst = 0; step();
    chk("R9 two-wire no request", 0, 0);
    grant_in = 1; step();
    chk("R9 two-wire idle", 0, 0);
    step();
    chk("R8 two-wire drive", 1, 0);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_idle_then_drive();
    t_hold_release();
    t_end_with_grant();
    t_wdog();
    t_grant_drop();
    t_two_wire();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got hang expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule